// File: doc/BRIEF.md
# Lane-Masked Synchronous RAM

This block is a single-port synchronous memory whose word width is fixed at elaboration to 16, 18, 32 or 36 bits. A write stores only the lanes of the word selected by a four-bit lane-enable vector. Every lane that is not selected keeps the value it held before. Lanes are 8 bits wide in the 16 and 32 bit widths and 9 bits wide in the 18 and 36 bit widths, so the ninth bit of each lane is written together with its byte.

Address, write data, write enable, read enable and lane enable are all taken on the rising clock edge. A sampled read returns the word one cycle later. An optional output register adds a second cycle of latency. When a read and a write fall in the same cycle, the read returns the merged word. The lane-enable input has no reset of its own. Tying it to all ones gives a plain word-wide RAM that is controlled by the write enable alone.

Top module: `lane_masked_ram`

## Requirements
- R1: While `rstN` is low, and after reset until the first sampled read, `rdData` is zero.
- R2: The memory changes only on a rising edge where `wrEn` is 1. With `wrEn` at 0, no lane is written, whatever `laneEn` holds.
- R3: `laneEn` is active high. Bit k selects lane k, and lane 0 is the least significant lane of the word. Only selected lanes take `wrData`. Every other lane keeps its previous value. Starting from all-ones contents in the 16-bit width, writing 0xABCD with `laneEn`=0010 stores 0xABFF, with 0001 stores 0xFFCD, and with 0011 stores 0xABCD.
- R4: In the 18 and 36 bit widths, lanes are 9 bits wide. Bit 0 covers data bits 8..0, bit 1 covers 17..9, bit 2 covers 26..18 and bit 3 covers 35..27.
- R5: In the 16 and 32 bit widths, lanes are 8 bits wide. Bit k covers data bits 8k+7..8k.
- R6: Any `laneEn` pattern is legal. All zeros with `wrEn`=1 leaves the word unchanged. All ones writes the whole word.
- R7: `laneEn` bits above the lane count of the chosen width are ignored. In the 16 and 18 bit widths, bits 3..2 have no effect.
- R8: With `OUT_REG`=0, `rdData` shows the addressed word in the cycle after a rising edge where `rdEn` is 1. It holds its value while `rdEn` is 0, even if writes take place.
- R9: With `OUT_REG`=1, `rdData` follows the same rule one cycle later.
- R10: A read and a write in the same cycle return the merged word. Only the enabled lanes show the new data.
- R11: Writes presented while `rstN` is low are dropped, and reset does not clear the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the read path |
| addr | input | ADDR_W | Word address (ADDR_W = clog2(DEPTH)) |
| wrData | input | DATA_W | Write word |
| wrEn | input | 1 | Write enable |
| rdEn | input | 1 | Read enable |
| laneEn | input | 4 | Per-lane write select, active high, bit 0 = lowest lane |
| rdData | output | DATA_W | Read word |

## Verification
Two instances share one stimulus: a 16-bit instance without the output register and a 36-bit instance with it. The same lane pattern therefore lands on 8-bit and 9-bit lane boundaries and at two latencies. The write 0xABCD under the patterns 0010, 0001 and 0011 over all-ones contents separates a correct lane order from a reversed or shifted one. The patterns 0000, 1111 and 1100 show whether the no-op, full-word and ignored-upper-bit cases are handled. A read and a write to one address in the same cycle show whether reads bypass the merge. A write during reset shows whether reset gates the write path. A long random run mixes all of these against a behavioural model that is compared on every clock.

// File: rtl/lane_ram_pkg.sv
package lane_ram_pkg;

  // Widest lane-enable vector the block accepts
  localparam int MAX_LANES = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic [MAX_LANES-1:0] laneWr;  // per-lane write strobe, already qualified
    logic                 rdLoad;  // capture the read word this edge
  } ramStrobe_t;

  // Lanes carry a ninth bit in the 18 and 36 bit widths
  function automatic int laneWidthFor(input int dataW);
    return ((dataW == 18) || (dataW == 36)) ? 9 : 8;
  endfunction

endpackage

// File: rtl/lane_ram_ctrl.sv
module lane_ram_ctrl
  import lane_ram_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [MAX_LANES-1:0] laneEn,
  output ramStrobe_t           strobe
);

  localparam int LANE_W    = laneWidthFor(DATA_W);
  localparam int NUM_LANES = DATA_W / LANE_W;

  logic [MAX_LANES-1:0] laneWrMask;

  // Lane bits beyond the configured lane count are dropped here (R7);
  // no write leaves while reset is held (R11).
  always_comb begin
    for (int i = 0; i < MAX_LANES; i++) begin
      laneWrMask[i] = (i < NUM_LANES) ? (rstN & wrEn & laneEn[i]) : 1'b0;
    end
  end

  assign strobe.laneWr = laneWrMask;
  assign strobe.rdLoad = rstN & rdEn;

endmodule

// File: rtl/lane_ram_datapath.sv
module lane_ram_datapath
  import lane_ram_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 32,
  parameter bit OUT_REG = 1'b0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DATA_W-1:0]        wrData,
  input  ramStrobe_t               strobe,
  output logic [DATA_W-1:0]        rdData
);

  localparam int LANE_W    = laneWidthFor(DATA_W);
  localparam int NUM_LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] memWord;
  logic [DATA_W-1:0] mergedWord;
  logic [DATA_W-1:0] rdStage;
  logic              anyWr;

  assign memWord = memArr[addr];
  assign anyWr   = |strobe.laneWr[NUM_LANES-1:0];

  // Per-lane merge of new data over the stored word
  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    assign mergedWord[g*LANE_W +: LANE_W] =
      strobe.laneWr[g] ? wrData[g*LANE_W +: LANE_W] : memWord[g*LANE_W +: LANE_W];

    // R3: an unselected lane reads back its old contents
    assert_lane_keep_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.rdLoad && !strobe.laneWr[g]) |=>
        rdStage[g*LANE_W +: LANE_W] == $past(memWord[g*LANE_W +: LANE_W]));
  end

  always_ff @(posedge clk) begin
    if (anyWr) memArr[addr] <= mergedWord;
  end

  // First read stage: captures the merged word, so a same-cycle write is seen (R10)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdStage <= '0;
    else if (strobe.rdLoad) rdStage <= mergedWord;
  end

  if (OUT_REG) begin : gOutReg
    logic [DATA_W-1:0] outQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outQ <= '0;
      else       outQ <= rdStage;
    end
    assign rdData = outQ;

    assert_out_delay_R9: assert property (@(posedge clk) disable iff (!rstN)
      rdData == $past(rdStage));
  end else begin : gDirect
    assign rdData = rdStage;
  end

  if (NUM_LANES < MAX_LANES) begin : gUpperQuiet
    assert_upper_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
      strobe.laneWr[MAX_LANES-1:NUM_LANES] == '0);
  end

  assert_full_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdLoad && (&strobe.laneWr[NUM_LANES-1:0])) |=> rdStage == $past(wrData));

  assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdLoad |=> $stable(rdStage));

endmodule

// File: rtl/lane_masked_ram.sv
module lane_masked_ram
  import lane_ram_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 32,
  parameter bit OUT_REG = 1'b0,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [MAX_LANES-1:0] laneEn,
  output logic [DATA_W-1:0]    rdData
);

  ramStrobe_t strobe;

  lane_ram_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .laneEn (laneEn),
    .strobe (strobe)
  );

  lane_ram_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OUT_REG(OUT_REG)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .wrData (wrData),
    .strobe (strobe),
    .rdData (rdData)
  );

endmodule

// File: tb/lane_masked_ram_tb_top.sv
module lane_masked_ram_tb_top;

  localparam int DEPTH = 32;
  localparam int AW    = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN   = 1'b0;
  logic          wrEn   = 1'b0;
  logic          rdEn   = 1'b0;
  logic [3:0]    laneEn = 4'hF;
  logic [AW-1:0] addr   = '0;
  logic [35:0]   wrData = '0;
  logic [15:0]   qNarrow;
  logic [35:0]   qWide;

  int    vectors  = 0;
  int    failures = 0;
  string curReq   = "R1";

  lane_masked_ram #(.DATA_W(16), .DEPTH(DEPTH), .OUT_REG(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData[15:0]),
    .wrEn(wrEn), .rdEn(rdEn), .laneEn(laneEn), .rdData(qNarrow));

  lane_masked_ram #(.DATA_W(36), .DEPTH(DEPTH), .OUT_REG(1'b1)) dutWide_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .laneEn(laneEn), .rdData(qWide));

  // Behavioural reference: one word array per instance, expected outputs as plain variables
  logic [15:0] refNarrow [DEPTH];
  logic [35:0] refWide   [DEPTH];
  logic [15:0] expNarrow = '0;
  logic [35:0] expWide1  = '0;
  logic [35:0] expWide2  = '0;

  always @(posedge clk) begin
    logic [15:0] nWord;
    logic [35:0] wWord;
    if (!rstN) begin
      expNarrow = '0; expWide1 = '0; expWide2 = '0;
    end else begin
      nWord = refNarrow[addr];
      wWord = refWide[addr];
      for (int k = 0; k < 2; k++)
        if (wrEn && laneEn[k]) nWord[k*8 +: 8] = wrData[k*8 +: 8];
      for (int k = 0; k < 4; k++)
        if (wrEn && laneEn[k]) wWord[k*9 +: 9] = wrData[k*9 +: 9];
      if (wrEn) begin
        refNarrow[addr] = nWord;
        refWide[addr]   = wWord;
      end
      expWide2 = expWide1;
      if (rdEn) begin
        expNarrow = nWord;
        expWide1  = wWord;
      end
    end
  end

  task automatic compare();
    vectors++;
    if (qNarrow !== expNarrow) begin
      failures++;
      $display("FAIL %s narrow: got %h expected %h", curReq, qNarrow, expNarrow);
    end
    vectors++;
    if (qWide !== expWide2) begin
      failures++;
      $display("FAIL %s wide: got %h expected %h", curReq, qWide, expWide2);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic [3:0] be,
                     input int a, input logic [35:0] d);
    @(negedge clk);
    compare();
    wrEn = w; rdEn = r; laneEn = be; addr = AW'(a); wrData = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 4'hF, 0, '0);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    idle(3);
    cyc(1'b0, 1'b0, 4'hF, 0, '0);
    rstN = 1'b1;
    idle(3);

    // Fill every word with all ones
    curReq = "R6";
    for (int a = 0; a < DEPTH; a++) cyc(1'b1, 1'b0, 4'hF, a, {36{1'b1}});
    idle(2);

    // R3: the 0xABCD example on both lane widths
    curReq = "R3";
    cyc(1'b1, 1'b0, 4'b0010, 0, 36'h0_0000_ABCD);
    cyc(1'b1, 1'b0, 4'b0001, 1, 36'h0_0000_ABCD);
    cyc(1'b1, 1'b0, 4'b0011, 2, 36'h0_0000_ABCD);
    for (int a = 0; a < 3; a++) cyc(1'b0, 1'b1, 4'hF, a, '0);
    idle(3);

    // R2: lane enables without write enable
    curReq = "R2";
    cyc(1'b0, 1'b0, 4'hF, 5, 36'h1_2345_6789);
    cyc(1'b0, 1'b1, 4'hF, 5, '0);
    idle(3);

    // R4 / R5: alternating lanes on 9-bit and 8-bit boundaries
    curReq = "R4";
    cyc(1'b1, 1'b0, 4'b0101, 6, 36'h9_8765_4321);
    cyc(1'b1, 1'b0, 4'b1010, 7, 36'h0_F0F0_0F0F);
    cyc(1'b0, 1'b1, 4'hF, 6, '0);
    cyc(1'b0, 1'b1, 4'hF, 7, '0);
    idle(3);
    curReq = "R5";
    cyc(1'b1, 1'b0, 4'b0010, 13, 36'h0_0000_5AA5);
    cyc(1'b0, 1'b1, 4'hF, 13, '0);
    idle(3);

    // R6: empty and full lane patterns
    curReq = "R6";
    cyc(1'b1, 1'b0, 4'b0000, 8, '0);
    cyc(1'b1, 1'b0, 4'b1111, 9, 36'hC_3C3C_A5A5);
    cyc(1'b0, 1'b1, 4'hF, 8, '0);
    cyc(1'b0, 1'b1, 4'hF, 9, '0);
    idle(3);

    // R7: upper lane bits on the narrow instance
    curReq = "R7";
    cyc(1'b1, 1'b0, 4'b1100, 10, '0);
    cyc(1'b0, 1'b1, 4'hF, 10, '0);
    idle(3);

    // R8: output holds while writes go elsewhere
    curReq = "R8";
    cyc(1'b0, 1'b1, 4'hF, 2, '0);
    cyc(1'b1, 1'b0, 4'hF, 11, 36'h5_5555_5555);
    cyc(1'b1, 1'b0, 4'hF, 2, 36'h0_0000_0000);
    idle(3);
    cyc(1'b0, 1'b1, 4'hF, 2, '0);
    idle(3);

    // R10: read and write in the same cycle
    curReq = "R10";
    cyc(1'b1, 1'b1, 4'b0010, 12, 36'h0_0001_2345);
    cyc(1'b1, 1'b1, 4'b1001, 12, 36'hE_DCBA_9876);
    idle(3);

    // R11: a write during reset is dropped and contents survive
    curReq = "R11";
    cyc(1'b0, 1'b0, 4'hF, 0, '0);
    rstN = 1'b0;
    cyc(1'b1, 1'b0, 4'hF, 3, '0);
    cyc(1'b1, 1'b1, 4'hF, 9, '0);
    cyc(1'b0, 1'b0, 4'hF, 0, '0);
    rstN = 1'b1;
    cyc(1'b0, 1'b1, 4'hF, 3, '0);
    cyc(1'b0, 1'b1, 4'hF, 9, '0);
    idle(3);

    // R9: random traffic, every compare includes the two-stage wide read path
    curReq = "R9";
    for (int i = 0; i < 400; i++) begin
      cyc(1'($urandom), 1'($urandom), 4'($urandom), int'($urandom % DEPTH),
          {4'($urandom), 32'($urandom)});
    end
    idle(4);

    finishRun();
  end

endmodule